// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Entry Unit

This block is the trap-entry stage of a small machine-mode-only RISC-V core that has capability extensions. The pipeline offers it one exception request at a time over a valid/ready handshake. Each request carries:

- a kind,
- a cause code,
- a trap value,
- the faulting PC,
- for capability faults, a selector naming the register at fault.

The block also watches the interrupt pending and enable vectors against its own global interrupt enable. Whenever a trap is taken, it:

- writes the cause, trap value and saved PC registers,
- stacks the interrupt enable,
- emits a one-cycle redirect pulse carrying the handler address.

The handler address comes from the address field of the trap-base capability. The two low bits of that address select direct or vectored dispatch. Capability faults always use cause 28. Their trap value packs the 5-bit fault cause with a 6-bit register index. A return-from-trap strobe brings the saved interrupt enable back. A plain write strobe lets software set the two enable bits of the status register.

Back-pressure rules:

- A request transfers on a rising clock edge where both `exc_valid` and `exc_ready` are high.
- `exc_ready` is low only in the cycle in which a redirect pulse is on the output.
- A requester must hold its fields stable until the transfer happens.
- The redirect output cannot be stalled: consumers must take `redir_pc` in the cycle `redir_valid` is high.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the status output reads 0x1800, the cause, trap value and saved PC outputs read 0, `redir_valid` is 0 and `exc_ready` is 1.
- R2: The handler address is `trap_base` with bits 1:0 cleared. When `trap_base[1:0]` is 1, the address is advanced by 4 times the cause code (bit 31 of the cause excluded). When `trap_base[1:0]` is 0, 2 or 3, every trap goes to the cleared base.
- R3: On every trap the cause output takes the cause code in its low bits. Bit 31 is 1 for interrupts and 0 for exceptions. For exception kind 0 (generic), the code is `exc_code` and the trap value is `exc_tval`.
- R4: On every trap the status output takes bit 3 (global enable) = 0 and bit 7 (previous enable) = the old bit 3, while bits 12:11 stay 3. The saved PC becomes `exc_pc` for an exception and `irq_pc` for an interrupt.
- R5: An interrupt is taken only when status bit 3 is 1 and `irq_pending & irq_enable` has at least one of bits 11, 3 or 7 set. The priority is bit 11, then bit 3, then bit 7, with cause codes 11, 3 and 7, and the trap value is 0. All other pending bits are ignored.
- R6: Exception kind 1 (capability fault) gives cause 28. The trap value is `exc_code | (index << 5)`, where the index depends on `exc_reg_sel`:
  - selectors 0 to 31 map to indices 0 to 31;
  - selector 32 (program-counter capability) maps to 0x20;
  - selectors 33, 34, 35 and 36 (trap-code, trap-data, scratch and exception-PC capabilities) map to 0x3C, 0x3D, 0x3E and 0x3F;
  - any other selector maps to 0x1F.
- R7: Exception kind 2 (environment call) gives cause 11 with trap value 0. Exception kind 3 (breakpoint) gives cause 3 with trap value equal to `exc_pc`.
- R8: An exception that transfers wins over a pending interrupt in the same cycle. A request held while `exc_ready` is low is not taken until the following cycle.
- R9: `redir_valid` is high for exactly the one cycle that follows a taken trap, with `redir_pc` valid in that cycle. The cause, trap value and saved PC outputs change in that same cycle.
- R10: A `mret_valid` strobe with no trap in the same cycle sets status bit 3 to the old bit 7 and sets bit 7 to 1, without a redirect.
- R11: A `csr_wr_en` strobe with no trap or return in the same cycle loads status bits 3 and 7 from `csr_wr_data` bits 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request valid |
| exc_ready | output | 1 | Exception request can transfer |
| exc_kind | input | 2 | 0 generic, 1 capability fault, 2 environment call, 3 breakpoint |
| exc_code | input | 5 | Generic cause code, or capability fault cause |
| exc_tval | input | 32 | Trap value for generic exceptions |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_reg_sel | input | 6 | Register selector for capability faults |
| irq_pending | input | 32 | Interrupt pending vector |
| irq_enable | input | 32 | Interrupt enable vector |
| irq_pc | input | 32 | PC saved when an interrupt is taken |
| trap_base | input | 32 | Trap-base capability address field |
| mret_valid | input | 1 | Return-from-trap strobe |
| csr_wr_en | input | 1 | Status enable-bit write strobe |
| csr_wr_data | input | 32 | Status write data (bits 3 and 7 used) |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Handler address |
| mcause_o | output | 32 | Cause register |
| mtval_o | output | 32 | Trap value register |
| mepc_o | output | 32 | Saved exception PC |
| mstatus_o | output | 32 | Status register |

## Verification
A corrupted global-enable or previous-enable bit shows up on `mstatus_o` in the cycle after the faulty edge. It also shows up as an interrupt that is taken or withheld against the pending vector, which is visible on `redir_valid` at once. A wrong picker or index map yields a wrong `mcause_o`, `mtval_o` or `redir_pc` in the very pulse cycle of the trap concerned. A redirect register that sticks or drops shows up as a pulse that lasts two cycles or never comes, and as `exc_ready` failing to drop or recover.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    EXC_GENERIC = 2'd0,
    EXC_CAP     = 2'd1,
    EXC_ECALL   = 2'd2,
    EXC_EBREAK  = 2'd3
  } exc_kind_e;

  localparam int CAUSE_W      = 5;
  localparam int CAP_IDX_W    = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_CAP_FAULT = 5'd28;
  localparam logic [CAUSE_W-1:0] CAUSE_ENV_CALL  = 5'd11;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK     = 5'd3;

  // interrupt line numbers, which double as their cause codes
  localparam int IRQ_EXT = 11;
  localparam int IRQ_SW  = 3;
  localparam int IRQ_TMR = 7;

  // capability register index encodings carried in the trap value
  localparam logic [CAP_IDX_W-1:0] IDX_PCC     = 6'h20;
  localparam logic [CAP_IDX_W-1:0] IDX_SPECIAL = 6'h3C;
  localparam logic [CAP_IDX_W-1:0] IDX_UNKNOWN = 6'h1F;

  // status register bit positions
  localparam int ST_GIE  = 3;
  localparam int ST_PGIE = 7;
  localparam int ST_PRIV = 11;

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CODE_W  = CAUSE_W
) (
  input  logic [XLEN-1:0]   pending,
  input  logic [XLEN-1:0]   enable,
  input  logic              gie,
  output logic              take,
  output logic [CODE_W-1:0] code
);
  localparam int NSRC = 3;
  // index 0 holds the highest priority
  localparam int PRIO [NSRC] = '{IRQ_EXT, IRQ_SW, IRQ_TMR};

  logic [XLEN-1:0] armed;
  logic            unused_armed;

  assign armed        = pending & enable;
  assign unused_armed = ^armed;

  always_comb begin
    take = 1'b0;
    code = '0;
    // walk from lowest to highest so the highest priority overwrites
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (gie && armed[PRIO[i]]) begin
        take = 1'b1;
        code = CODE_W'(PRIO[i]);
      end
    end
  end

  // R5: a picked interrupt is always one of the three machine sources
  always_comb begin
    if (take) begin
      a_r5_known_source: assert (code == CODE_W'(IRQ_EXT) ||
                                 code == CODE_W'(IRQ_SW)  ||
                                 code == CODE_W'(IRQ_TMR));
    end
  end

endmodule

// File: rtl/trap_cause_form.sv
module trap_cause_form
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = CAUSE_W,
  parameter int IDX_W  = CAP_IDX_W,
  parameter int SEL_W  = 6,
  parameter int NGPR   = 32,
  parameter int NSPEC  = 4
) (
  input  exc_kind_e         kind,
  input  logic [CODE_W-1:0] code_in,
  input  logic [XLEN-1:0]   tval_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [SEL_W-1:0]  reg_sel,
  output logic [CODE_W-1:0] cause,
  output logic [XLEN-1:0]   tval
);
  localparam int SEL_PCC   = NGPR;
  localparam int SEL_SPEC0 = NGPR + 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    if (int'(reg_sel) < NGPR) begin
      idx = IDX_W'(reg_sel);
    end else if (int'(reg_sel) == SEL_PCC) begin
      idx = IDX_PCC;
    end else if (int'(reg_sel) < SEL_SPEC0 + NSPEC) begin
      idx = IDX_SPECIAL + IDX_W'(int'(reg_sel) - SEL_SPEC0);
    end else begin
      idx = IDX_UNKNOWN;
    end
  end

  always_comb begin
    unique case (kind)
      EXC_CAP: begin
        cause = CAUSE_CAP_FAULT;
        tval  = XLEN'(code_in) | (XLEN'(idx) << CODE_W);
      end
      EXC_ECALL: begin
        cause = CAUSE_ENV_CALL;
        tval  = '0;
      end
      EXC_EBREAK: begin
        cause = CAUSE_BREAK;
        tval  = pc_in;
      end
      default: begin
        cause = code_in;
        tval  = tval_in;
      end
    endcase
  end

  // R6: a capability trap value never reaches past the index field
  always_comb begin
    if (kind == EXC_CAP) begin
      a_r6_field_width: assert (tval[XLEN-1:CODE_W+IDX_W] == '0);
    end
  end

endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [XLEN-1:0]   base,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  localparam logic [1:0] MODE_VECTORED = 2'd1;

  logic [XLEN-1:0] aligned;

  assign aligned = {base[XLEN-1:2], 2'b00};

  always_comb begin
    if (base[1:0] == MODE_VECTORED) target = aligned + (XLEN'(code) << 2);
    else                            target = aligned;
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = CAUSE_W,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  output logic              exc_ready,
  input  logic [1:0]        exc_kind,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [SEL_W-1:0]  exc_reg_sel,
  input  logic [XLEN-1:0]   irq_pending,
  input  logic [XLEN-1:0]   irq_enable,
  input  logic [XLEN-1:0]   irq_pc,
  input  logic [XLEN-1:0]   trap_base,
  input  logic              mret_valid,
  input  logic              csr_wr_en,
  input  logic [XLEN-1:0]   csr_wr_data,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mstatus_o
);
  logic              gie_q, pgie_q, redir_q;
  logic [XLEN-1:0]   cause_q, tval_q, epc_q, tgt_q;

  logic              irq_take;
  logic [CODE_W-1:0] irq_code;
  logic [CODE_W-1:0] exc_cause;
  logic [XLEN-1:0]   exc_tval_f;
  logic              take_exc, take_irq, take_any;
  logic [CODE_W-1:0] sel_code;
  logic [XLEN-1:0]   sel_tval, sel_epc, sel_tgt;
  logic              unused_wdata;

  assign unused_wdata = ^{csr_wr_data[XLEN-1:ST_PGIE+1],
                          csr_wr_data[ST_PGIE-1:ST_GIE+1],
                          csr_wr_data[ST_GIE-1:0]};

  trap_irq_pick #(.XLEN(XLEN), .CODE_W(CODE_W)) u_pick (
    .pending (irq_pending),
    .enable  (irq_enable),
    .gie     (gie_q),
    .take    (irq_take),
    .code    (irq_code)
  );

  trap_cause_form #(.XLEN(XLEN), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_form (
    .kind    (exc_kind_e'(exc_kind)),
    .code_in (exc_code),
    .tval_in (exc_tval),
    .pc_in   (exc_pc),
    .reg_sel (exc_reg_sel),
    .cause   (exc_cause),
    .tval    (exc_tval_f)
  );

  assign exc_ready = !redir_q;
  assign take_exc  = exc_valid && exc_ready;
  assign take_irq  = !take_exc && !redir_q && irq_take;
  assign take_any  = take_exc || take_irq;

  assign sel_code  = take_exc ? exc_cause  : irq_code;
  assign sel_tval  = take_exc ? exc_tval_f : '0;
  assign sel_epc   = take_exc ? exc_pc     : irq_pc;

  trap_vec_calc #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .base   (trap_base),
    .code   (sel_code),
    .target (sel_tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      pgie_q  <= 1'b0;
      redir_q <= 1'b0;
      cause_q <= '0;
      tval_q  <= '0;
      epc_q   <= '0;
      tgt_q   <= '0;
    end else begin
      redir_q <= take_any;
      if (take_any) begin
        cause_q <= {take_irq, {(XLEN-1-CODE_W){1'b0}}, sel_code};
        tval_q  <= sel_tval;
        epc_q   <= sel_epc;
        tgt_q   <= sel_tgt;
        pgie_q  <= gie_q;
        gie_q   <= 1'b0;
      end else if (mret_valid) begin
        gie_q   <= pgie_q;
        pgie_q  <= 1'b1;
      end else if (csr_wr_en) begin
        gie_q   <= csr_wr_data[ST_GIE];
        pgie_q  <= csr_wr_data[ST_PGIE];
      end
    end
  end

  always_comb begin
    mstatus_o                      = '0;
    mstatus_o[ST_PRIV+1:ST_PRIV]   = 2'b11;
    mstatus_o[ST_PGIE]             = pgie_q;
    mstatus_o[ST_GIE]              = gie_q;
  end

  assign redir_valid = redir_q;
  assign redir_pc    = tgt_q;
  assign mcause_o    = cause_q;
  assign mtval_o     = tval_q;
  assign mepc_o      = epc_q;

  // R9: the redirect never lasts more than one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  // R4: the global enable is off while a redirect is presented
  a_r4_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !mstatus_o[ST_GIE]);

  // R4: the previous enable captures the enable seen before the trap
  a_r4_pgie_stacked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> mstatus_o[ST_PGIE] == $past(mstatus_o[ST_GIE]));

  // R8: a transferred request produces a redirect saving its PC
  a_r8_accept_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_ready) |=> redir_valid && mepc_o == $past(exc_pc));

  // R2: every handler address is word aligned
  a_r2_aligned_target: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_pc[1:0] == 2'b00);

  // R5: an interrupt redirect requires the enable that was set before it
  a_r5_gated_by_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && mcause_o[XLEN-1]) |-> $past(mstatus_o[ST_GIE]));

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;

  typedef struct packed {
    logic [31:0] base;
    logic [1:0]  kind;
    logic [4:0]  code;
    logic [31:0] tval;
    logic [31:0] pc;
    logic [5:0]  sel;
    logic [31:0] ecause;
    logic [31:0] etval;
    logic [31:0] etgt;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TBL [NVEC] = '{
    '{32'h1000_0100, 2'd0, 5'h05, 32'hDEAD_BEEF, 32'h2000_0010, 6'd0,  32'h05, 32'hDEAD_BEEF, 32'h1000_0100},
    '{32'h1000_0101, 2'd0, 5'h07, 32'h0000_0044, 32'h2000_0014, 6'd0,  32'h07, 32'h0000_0044, 32'h1000_011C},
    '{32'h1000_0103, 2'd0, 5'h02, 32'h0000_1234, 32'h2000_0018, 6'd0,  32'h02, 32'h0000_1234, 32'h1000_0100},
    '{32'h2000_0002, 2'd1, 5'h13, 32'hFFFF_FFFF, 32'h2000_001C, 6'd5,  32'h1C, 32'h0000_00B3, 32'h2000_0000},
    '{32'h2000_0000, 2'd1, 5'h01, 32'h0,         32'h2000_0020, 6'd32, 32'h1C, 32'h0000_0401, 32'h2000_0000},
    '{32'h2000_0000, 2'd1, 5'h1F, 32'h0,         32'h2000_0024, 6'd36, 32'h1C, 32'h0000_07FF, 32'h2000_0000},
    '{32'h2000_0000, 2'd1, 5'h02, 32'h0,         32'h2000_0028, 6'd33, 32'h1C, 32'h0000_0782, 32'h2000_0000},
    '{32'h3000_0001, 2'd1, 5'h03, 32'h0,         32'h2000_002C, 6'd40, 32'h1C, 32'h0000_03E3, 32'h3000_0070},
    '{32'h3000_0001, 2'd2, 5'h00, 32'h0000_0055, 32'h4000_0008, 6'd0,  32'h0B, 32'h0,         32'h3000_002C},
    '{32'h3000_0000, 2'd3, 5'h00, 32'h0000_0055, 32'h4000_000C, 6'd0,  32'h03, 32'h4000_000C, 32'h3000_0000},
    '{32'h3000_0000, 2'd1, 5'h08, 32'h0,         32'h4000_0010, 6'd31, 32'h1C, 32'h0000_03E8, 32'h3000_0000},
    '{32'h3000_0001, 2'd1, 5'h04, 32'h0,         32'h4000_0014, 6'd34, 32'h1C, 32'h0000_07A4, 32'h3000_0070},
    '{32'h3000_0000, 2'd1, 5'h00, 32'h0,         32'h4000_0018, 6'd35, 32'h1C, 32'h0000_07C0, 32'h3000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic        exc_ready;
  logic [1:0]  exc_kind = '0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_tval = '0;
  logic [31:0] exc_pc = '0;
  logic [5:0]  exc_reg_sel = '0;
  logic [31:0] irq_pending = '0;
  logic [31:0] irq_enable = '0;
  logic [31:0] irq_pc = '0;
  logic [31:0] trap_base = '0;
  logic        mret_valid = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic        redir_valid;
  logic [31:0] redir_pc, mcause_o, mtval_o, mepc_o, mstatus_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_kind(exc_kind),
    .exc_code(exc_code), .exc_tval(exc_tval), .exc_pc(exc_pc),
    .exc_reg_sel(exc_reg_sel), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .irq_pc(irq_pc), .trap_base(trap_base),
    .mret_valid(mret_valid), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .mcause_o(mcause_o),
    .mtval_o(mtval_o), .mepc_o(mepc_o), .mstatus_o(mstatus_o)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic do_mret();
    @(negedge clk);
    mret_valid = 1'b1;
    @(negedge clk);
    mret_valid = 1'b0;
  endtask

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 mstatus", mstatus_o, 32'h1800);
    chk("R1 mcause", mcause_o, 32'h0);
    chk("R1 mtval", mtval_o, 32'h0);
    chk("R1 mepc", mepc_o, 32'h0);
    chk("R1 redir_valid", {31'b0, redir_valid}, 32'h0);
    chk("R1 exc_ready", {31'b0, exc_ready}, 32'h1);

    // table of exceptions
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      trap_base = TBL[i].base; exc_kind = TBL[i].kind; exc_code = TBL[i].code;
      exc_tval = TBL[i].tval; exc_pc = TBL[i].pc; exc_reg_sel = TBL[i].sel;
      exc_valid = 1'b1;
      @(negedge clk);
      exc_valid = 1'b0;
      tag = (TBL[i].kind == 2'd1) ? "R6" : (TBL[i].kind == 2'd0) ? "R3" : "R7";
      chk($sformatf("R9 redir_valid vec %0d", i), {31'b0, redir_valid}, 32'h1);
      chk($sformatf("R2 redir_pc vec %0d", i), redir_pc, TBL[i].etgt);
      chk($sformatf("%s mcause vec %0d", tag, i), mcause_o, TBL[i].ecause);
      chk($sformatf("%s mtval vec %0d", tag, i), mtval_o, TBL[i].etval);
      chk($sformatf("R4 mepc vec %0d", i), mepc_o, TBL[i].pc);
      chk($sformatf("R4 mstatus vec %0d", i), mstatus_o, 32'h1800);
    end

    // R8 R9: back-to-back requests
    @(negedge clk);
    trap_base = 32'h1000_0000; exc_kind = 2'd0; exc_code = 5'd4;
    exc_pc = 32'hA000_0000; exc_valid = 1'b1;
    @(negedge clk);
    chk("R9 pulse first", {31'b0, redir_valid}, 32'h1);
    chk("R8 ready low in pulse", {31'b0, exc_ready}, 32'h0);
    exc_pc = 32'hA000_0004;
    @(negedge clk);
    chk("R9 pulse ends", {31'b0, redir_valid}, 32'h0);
    chk("R8 held request not taken", mepc_o, 32'hA000_0000);
    @(negedge clk);
    exc_valid = 1'b0;
    chk("R8 held request taken", mepc_o, 32'hA000_0004);
    chk("R9 second pulse", {31'b0, redir_valid}, 32'h1);
    @(negedge clk);

    // R11: enable write; R5: unrelated pending bit ignored
    csr_write(32'h0000_0008);
    chk("R11 mstatus after write", mstatus_o, 32'h1808);
    irq_enable = 32'hFFFF_FFFF; irq_pending = 32'h0000_0020;
    trap_base = 32'h5000_0001; irq_pc = 32'h6000_0000;
    repeat (3) @(negedge clk);
    chk("R5 bit5 ignored", {31'b0, redir_valid}, 32'h0);

    // R5: external first
    irq_pending = 32'h0000_08A8;
    @(negedge clk);
    irq_pending = '0;
    chk("R5 ext redirect", {31'b0, redir_valid}, 32'h1);
    chk("R3 ext mcause", mcause_o, 32'h8000_000B);
    chk("R2 ext vectored pc", redir_pc, 32'h5000_002C);
    chk("R5 irq mtval zero", mtval_o, 32'h0);
    chk("R4 irq mepc", mepc_o, 32'h6000_0000);
    chk("R4 irq mstatus", mstatus_o, 32'h1880);
    do_mret();
    chk("R10 mret mstatus", mstatus_o, 32'h1888);
    chk("R10 mret no redirect", {31'b0, redir_valid}, 32'h0);

    // R5: software above timer
    irq_pending = 32'h0000_0088;
    @(negedge clk);
    irq_pending = '0;
    chk("R5 sw mcause", mcause_o, 32'h8000_0003);
    chk("R2 sw vectored pc", redir_pc, 32'h5000_000C);
    do_mret();

    // R5: timer alone
    irq_pending = 32'h0000_0080;
    @(negedge clk);
    irq_pending = '0;
    chk("R5 tmr mcause", mcause_o, 32'h8000_0007);
    chk("R2 tmr vectored pc", redir_pc, 32'h5000_001C);
    do_mret();

    // R5: global enable off blocks interrupts
    csr_write(32'h0000_0000);
    chk("R11 mstatus cleared", mstatus_o, 32'h1800);
    irq_pending = 32'h0000_0888;
    repeat (3) @(negedge clk);
    chk("R5 gated by enable", {31'b0, redir_valid}, 32'h0);
    irq_pending = '0;

    // R8: exception beats interrupt in the same cycle
    csr_write(32'h0000_0008);
    @(negedge clk);
    trap_base = 32'h5000_0000; exc_kind = 2'd2; exc_pc = 32'h7000_0000;
    exc_valid = 1'b1; irq_pending = 32'h0000_0080;
    @(negedge clk);
    exc_valid = 1'b0;
    chk("R8 exception wins mcause", mcause_o, 32'h0000_000B);
    chk("R8 exception wins mepc", mepc_o, 32'h7000_0000);
    chk("R4 stacked enable", mstatus_o, 32'h1880);
    @(negedge clk);
    chk("R8 no follow-on irq", {31'b0, redir_valid}, 32'h0);
    irq_pending = '0;

    finish_run();
  end

endmodule